// File: doc/BRIEF.md
# Extended Arithmetic Sequencer

This block is a multi-cycle arithmetic engine that works on three 16-bit registers. X and Y together form a 32-bit pair, with X as the upper half. G serves as the low word in multiply and divide, and as the step counter in shift and normalize. The block runs four commands: unsigned multiply, unsigned divide with an overflow check, arithmetic right shift by a count held in G, and normalize. The shift and normalize commands move one bit per clock. Multiply uses a 16-step shift-and-add loop. Divide uses a 16-step restoring loop.

To issue a command, the surrounding datapath presents X, Y and G on the operand inputs and pulses `start` with a 2-bit opcode. The block holds `busy` high until it pulses `done`, and it ignores any new `start` while busy. When `done` is high the results are valid on `x_out`, `y_out` and `g_out`, and they stay there until the next accepted command. The `link` output reports a divide overflow, or the sign bit that an arithmetic shift moved out. The opcode encoding is: 0 multiply, 1 divide, 2 arithmetic right shift, 3 normalize.

Top module: `eao_unit`

## Requirements
- R1: A `start` seen in an idle cycle is accepted on that clock edge. `busy` is high from the next cycle until `done`. `done` is a one-cycle pulse. When a command takes N steps, `done` is high in the cycle after the Nth edge that follows the accepting edge, and the cycle after `done` is idle.
- R2: Multiply (opcode 0) puts the high half of the unsigned product X*Y in X and the low half in G. Y keeps its value.
- R3: Multiply always takes 16 steps. Multiply and normalize leave `link` unchanged.
- R4: Divide (opcode 1) with Y nonzero and X < Y divides the 32-bit value {X,G} by Y. The quotient goes to G and the remainder to X, `link` is cleared, the command takes 16 steps, and Y keeps its value.
- R5: Divide with Y zero or X >= Y returns the X and G operands unchanged, sets `link`, and finishes after 0 steps.
- R6: Arithmetic right shift (opcode 2) copies bit 15 of the X operand into `link` when the command is accepted.
- R7: Each shift step moves {X,Y} right by one bit. The sign of X is kept in bit 15, bit 0 of X moves into bit 15 of Y, and G is incremented. Shifting stops after the step that brings G to zero.
- R8: A shift always performs at least one step and never more than 32. With G = 0 it therefore runs exactly 32 steps.
- R9: Normalize (opcode 3) with X and Y both zero changes nothing and finishes after 0 steps.
- R10: Otherwise each normalize step shifts {X,Y} left by one bit with a zero into bit 0 of Y, and increments G. The command stops once bit 15 of X differs from bit 14. If they already differ, it takes 0 steps.
- R11: A `start` that arrives while `busy` is high is ignored. The running command completes with its own result and timing.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, sampled in idle cycles |
| opcode | input | 2 | Command: 0 mul, 1 div, 2 shift right, 3 normalize |
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand |
| g_in | input | 16 | G operand (low word or count) |
| x_out | output | 16 | X register |
| y_out | output | 16 | Y register |
| g_out | output | 16 | G register |
| link | output | 1 | Divide overflow or shifted-out sign |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after the stop conditions of the shift.

- A count of zero must run the full 32 steps. A design that tested G before stepping would stop at once.
- A count of all ones must stop after one step.
- For divide, X equal to Y and Y equal to zero must both set link and leave the operands in place. A design with the wrong comparison would produce a garbage quotient instead.
- For normalize, the bench covers an all-zero pair, an operand whose top bits already differ, and a single bit at the bottom of Y. These expose loops that never end, take one step too many, or count G wrongly.
- A second start is sent during a long multiply. A design that accepted it would return the wrong product or the wrong latency.

// File: rtl/eao_pkg.sv
package eao_pkg;
    localparam int EAO_W = 16;

    typedef enum logic [1:0] {
        OP_MUL  = 2'd0,
        OP_DIV  = 2'd1,
        OP_ASR  = 2'd2,
        OP_NORM = 2'd3
    } eao_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } eao_st_e;

    // True when the two top bits of a word disagree (normalized form).
    function automatic logic top_pair_differs(input logic hi, input logic nxt);
        return hi ^ nxt;
    endfunction
endpackage

// File: rtl/eao_datapath.sv
module eao_datapath
    import eao_pkg::*;
#(
    parameter int W = EAO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  eao_op_e      op_in,
    input  eao_op_e      op_run,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic [W-1:0] g_in,
    output logic [W-1:0] x_q,
    output logic [W-1:0] y_q,
    output logic [W-1:0] g_q,
    output logic         link_q,
    output logic         imm_fin,
    output logic         g_wrap,
    output logic         norm_hit
);
    logic [W-1:0] x_n, y_n, g_n;
    logic [W:0]   mul_sum;
    logic [W:0]   div_rem;
    logic [W:0]   div_diff;
    logic         div_fit;
    logic         div_ok;

    assign div_ok = (y_in != '0) && (x_in < y_in);

    always_comb begin
        imm_fin = 1'b0;
        if (op_in == OP_DIV && !div_ok)
            imm_fin = 1'b1;
        if (op_in == OP_NORM &&
            (((x_in | y_in) == '0) || top_pair_differs(x_in[W-1], x_in[W-2])))
            imm_fin = 1'b1;
    end

    always_comb begin
        mul_sum  = {1'b0, x_q} + (g_q[0] ? {1'b0, y_q} : '0);
        div_rem  = {x_q, g_q[W-1]};
        div_fit  = div_rem >= {1'b0, y_q};
        div_diff = div_rem - {1'b0, y_q};
        x_n = x_q;
        y_n = y_q;
        g_n = g_q;
        unique case (op_run)
            OP_MUL: begin
                x_n = mul_sum[W:1];
                g_n = {mul_sum[0], g_q[W-1:1]};
            end
            OP_DIV: begin
                x_n = div_fit ? div_diff[W-1:0] : div_rem[W-1:0];
                g_n = {g_q[W-2:0], div_fit};
            end
            OP_ASR: begin
                x_n = {x_q[W-1], x_q[W-1:1]};
                y_n = {x_q[0], y_q[W-1:1]};
                g_n = g_q + 1'b1;
            end
            OP_NORM: begin
                x_n = {x_q[W-2:0], y_q[W-1]};
                y_n = {y_q[W-2:0], 1'b0};
                g_n = g_q + 1'b1;
            end
        endcase
        g_wrap   = (g_n == '0);
        norm_hit = top_pair_differs(x_n[W-1], x_n[W-2]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            y_q    <= '0;
            g_q    <= '0;
            link_q <= 1'b0;
        end else if (load) begin
            y_q <= y_in;
            if (op_in == OP_MUL) begin
                x_q <= '0;
                g_q <= x_in;
            end else begin
                x_q <= x_in;
                g_q <= g_in;
            end
            if (op_in == OP_DIV) link_q <= !div_ok;
            if (op_in == OP_ASR) link_q <= x_in[W-1];
        end else if (step) begin
            x_q <= x_n;
            y_q <= y_n;
            g_q <= g_n;
        end
    end

    // R6: shift takes the operand sign into link
    a_r6_shift_link: assert property (@(posedge clk) disable iff (rst)
        (load && op_in == OP_ASR) |=> (link_q == $past(x_in[W-1])));

    // R5: divide overflow keeps the operands and raises link
    a_r5_div_overflow: assert property (@(posedge clk) disable iff (rst)
        (load && op_in == OP_DIV && (y_in == '0 || x_in >= y_in))
        |=> (link_q && x_q == $past(x_in) && g_q == $past(g_in)));
endmodule

// File: rtl/eao_ctrl.sv
module eao_ctrl
    import eao_pkg::*;
#(
    parameter int W = EAO_W
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  eao_op_e op_in,
    input  logic    imm_fin,
    input  logic    g_wrap,
    input  logic    norm_hit,
    output logic    load,
    output logic    step,
    output logic    busy,
    output logic    done,
    output eao_op_e op_q
);
    localparam int LIMIT = 2 * W;
    localparam int CW    = $clog2(LIMIT);

    eao_st_e       st;
    logic [CW-1:0] cnt;
    logic          last;

    assign load = (st == ST_IDLE) && start;
    assign step = (st == ST_RUN);
    assign busy = (st != ST_IDLE);
    assign done = (st == ST_FIN);

    always_comb begin
        unique case (op_q)
            OP_MUL, OP_DIV: last = (cnt == CW'(W - 1));
            OP_ASR:         last = g_wrap || (cnt == CW'(LIMIT - 1));
            OP_NORM:        last = norm_hit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            op_q <= OP_MUL;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    op_q <= op_in;
                    cnt  <= '0;
                    st   <= imm_fin ? ST_FIN : ST_RUN;
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (last) st <= ST_FIN;
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1: done is a single pulse inside the busy window
    a_r1_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
endmodule

// File: rtl/eao_unit.sv
module eao_unit
    import eao_pkg::*;
#(
    parameter int W = EAO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   opcode,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic [W-1:0] g_in,
    output logic [W-1:0] x_out,
    output logic [W-1:0] y_out,
    output logic [W-1:0] g_out,
    output logic         link,
    output logic         busy,
    output logic         done
);
    eao_op_e op_in;
    eao_op_e op_q;
    logic    load, step, imm_fin, g_wrap, norm_hit;

    assign op_in = eao_op_e'(opcode);

    eao_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .op_in(op_in),
        .imm_fin(imm_fin), .g_wrap(g_wrap), .norm_hit(norm_hit),
        .load(load), .step(step), .busy(busy), .done(done), .op_q(op_q)
    );

    eao_datapath #(.W(W)) u_dp (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .op_in(op_in), .op_run(op_q),
        .x_in(x_in), .y_in(y_in), .g_in(g_in),
        .x_q(x_out), .y_q(y_out), .g_q(g_out), .link_q(link),
        .imm_fin(imm_fin), .g_wrap(g_wrap), .norm_hit(norm_hit)
    );

    // R9: all-zero normalize finishes at once with the operands intact
    a_r9_norm_zero: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && opcode == 2'd3 && x_in == '0 && y_in == '0)
        |=> (done && x_out == '0 && y_out == '0 && g_out == $past(g_in)));

    // R10: a finished nonzero normalize leaves X normalized
    a_r10_norm_result: assert property (@(posedge clk) disable iff (rst)
        (done && op_q == OP_NORM && (x_out | y_out) != '0)
        |-> (x_out[W-1] != x_out[W-2]));

    // R11: a start while busy does not replace the running command
    a_r11_ignore_busy_start: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(op_q));
endmodule

// File: tb/eao_unit_bench.sv
module eao_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  opcode;
    logic [15:0] x_in, y_in, g_in;
    logic [15:0] x_out, y_out, g_out;
    logic        link, busy, done;

    int n_checks = 0;
    int n_fail   = 0;
    logic exp_link = 1'b0;
    logic finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eao_unit u_eao_unit (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .x_in(x_in), .y_in(y_in), .g_in(g_in),
        .x_out(x_out), .y_out(y_out), .g_out(g_out),
        .link(link), .busy(busy), .done(done)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: returns expected registers, link and step count.
    task automatic model(input logic [1:0] op, input logic [15:0] xi, yi, gi,
                         output logic [15:0] xo, yo, go, output logic lk,
                         output int steps);
        logic [31:0] p;
        xo = xi; yo = yi; go = gi; lk = exp_link; steps = 0;
        case (op)
            2'd0: begin
                p = xi * yi; xo = p[31:16]; go = p[15:0]; steps = 16;
            end
            2'd1: begin
                if (yi != 0 && xi < yi) begin
                    p = {xi, gi};
                    go = 16'(p / yi); xo = 16'(p % yi); lk = 1'b0; steps = 16;
                end else lk = 1'b1;
            end
            2'd2: begin
                lk = xi[15];
                do begin
                    yo = {xo[0], yo[15:1]};
                    xo = {xo[15], xo[15:1]};
                    go = go + 1'b1;
                    steps++;
                end while (go != 0 && steps < 32);
            end
            default: begin
                if ((xi | yi) != 0) begin
                    while (xo[15] == xo[14]) begin
                        xo = {xo[14:0], yo[15]};
                        yo = {yo[14:0], 1'b0};
                        go = go + 1'b1;
                        steps++;
                    end
                end
            end
        endcase
    endtask

    function automatic string tag_of(input logic [1:0] op, input logic [15:0] xi, yi);
        case (op)
            2'd0: return "R2";
            2'd1: return (yi != 0 && xi < yi) ? "R4" : "R5";
            2'd2: return "R7";
            default: return ((xi | yi) == 0) ? "R9" : "R10";
        endcase
    endfunction

    // Issue a command; optionally pulse start again mid-run (R11).
    task automatic run_op(input logic [1:0] op, input logic [15:0] xi, yi, gi,
                          input logic poke);
        logic [15:0] ex, ey, eg;
        logic el;
        int es, k;
        logic busy_ok;
        string t;
        model(op, xi, yi, gi, ex, ey, eg, el, es);
        t = tag_of(op, xi, yi);
        @(negedge clk);
        start = 1'b1; opcode = op; x_in = xi; y_in = yi; g_in = gi;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        x_in = ~xi; y_in = ~yi; g_in = ~gi;
        k = 0;
        busy_ok = 1'b1;
        while (!done && k < 80) begin
            if (!busy) busy_ok = 1'b0;
            if (poke && k == 3) begin
                start = 1'b1; opcode = 2'd3;
            end else start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        chk(x_out == ex, {t, " x"}, x_out, ex);
        chk(y_out == ey, {t, " y"}, y_out, ey);
        chk(g_out == eg, {t, " g"}, g_out, eg);
        chk(link == el, (op == 2'd2) ? "R6 link" :
                        (op == 2'd0 || op == 2'd3) ? "R3 link kept" : {t, " link"}, link, el);
        chk(k == es, poke ? "R11 latency" :
                     (op == 2'd2) ? "R8 steps" : "R1 latency", k, es);
        chk(busy_ok && busy, "R1 busy", busy, 1);
        @(posedge clk);
        @(negedge clk);
        chk(!done && !busy, "R1 idle after done", {busy, done}, 0);
        exp_link = el;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; start = 1'b0; opcode = 2'd0;
        x_in = '0; y_in = '0; g_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk({x_out, y_out, g_out} == 0 && !link && !busy && !done,
            "R12 reset", {link, busy, done}, 0);

        // Directed corners
        run_op(2'd0, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0);
        run_op(2'd0, 16'h1234, 16'h0000, 16'h5555, 1'b0);
        run_op(2'd1, 16'h0001, 16'h0003, 16'h0005, 1'b0);
        run_op(2'd1, 16'h0007, 16'h0007, 16'h1111, 1'b0);
        run_op(2'd1, 16'h0002, 16'h0000, 16'h2222, 1'b0);
        run_op(2'd2, 16'h8001, 16'h0000, 16'h0000, 1'b0);
        run_op(2'd2, 16'h4003, 16'hF0F0, 16'hFFFF, 1'b0);
        run_op(2'd2, 16'h9ABC, 16'h1234, 16'hFFFB, 1'b0);
        run_op(2'd3, 16'h0000, 16'h0000, 16'h0042, 1'b0);
        run_op(2'd3, 16'h4000, 16'h0000, 16'h0000, 1'b0);
        run_op(2'd3, 16'h0000, 16'h0001, 16'h0000, 1'b0);
        run_op(2'd3, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0);
        run_op(2'd0, 16'hBEEF, 16'h0123, 16'h0000, 1'b1);

        // Constrained random
        for (int i = 0; i < 60; i++) begin
            logic [1:0]  op;
            logic [15:0] a, b, c;
            op = 2'($urandom_range(0, 3));
            a = 16'($urandom);
            b = 16'($urandom);
            c = 16'($urandom);
            if (op == 2'd1 && (i % 3) != 0 && b != 0) a = a % b;
            if (op == 2'd2 && (i % 2) == 0) c = 16'hFFFF - 16'($urandom_range(0, 40));
            if (op == 2'd3 && (i % 2) == 0) a = a >> $urandom_range(0, 15);
            run_op(op, a, b, c, (i % 7) == 0);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule